// File: doc/BRIEF.md
# Double-Buffered Frame Fetch Sequencer

This block sequences the memory reads for one display frame at a time, from one of two frame buffers. On each frame tick it fetches a 512-byte palette header from the start of the current buffer. It takes the pixel depth from bits 14:12 of the header's first 16-bit word and works out where the pixel data begins. It then checks that the whole frame fits inside the buffer. If it fits, the block issues one read request per display line over a valid/ready channel. Each request carries a byte address and a byte length.

In dual mode the two buffers alternate from frame to frame. A subpanel setting can move the first fetched line or shorten the number of lines. Frame-start and error events set sticky condition bits and raise one-cycle interrupt pulses. A frame that does not fit stops the controller with a sync error. Bad buffer bounds at enable time stop it with an error condition. A stopped controller stays stopped until the enable input is dropped and raised again.

Top module: `frame_fetch_seq`

## Requirements
- R1: After reset, `busy_o`, `active_o`, `rd_valid_o`, `sync_err_o` and both interrupt pulses are 0, `cond_o` is 0 and `cur_buf_o` is 2'b11, the idle code.
- R2: When `en_i` is low, `active_o` and `sync_err_o` clear and `cur_buf_o` returns to 2'b11 one cycle later. A rising `en_i` with good bounds sets `active_o` and selects buffer 0.
- R3: `bound_ok_i` bits are buffer 0 top, buffer 0 bottom, buffer 1 top and buffer 1 bottom, from bit 0 upward. On a rising `en_i`, if a buffer 0 bit is low, or a buffer 1 bit is low while `dual_i` is set, the block sets `cond_o[2]`, pulses `err_irq_o` if `irq_mask_i[1]` is set, and leaves `active_o` low.
- R4: A frame tick while active starts a frame unless the palette mode is 1. A tick while inactive or in mode 1 issues no request. Outside mode 2, the first request has `rd_line_o`=0, the address is the current buffer's top and the length is 512.
- R5: The depth code is header bits 14:12. Code 1 gives 2 bits per pixel, code 2 gives 4, code 3 gives 8 and codes 4 to 7 give 16. Code 0 ends the frame with no line request and no change to `cond_o`, the buffer or `active_o`.
- R6: Pixel data starts 512 bytes into the buffer for codes 3 to 7 and 32 bytes in for codes 1 and 2. In palette mode 2 no header is read, the data starts at offset 0, and the code last captured is used. That code resets to 0.
- R7: Let size be bottom minus top of the current buffer. If offset + width*height*bpp/8 > size + 2, the block sets `sync_err_o`, clears `active_o`, and issues no line request, with no condition bit set.
- R8: A frame that fits sets `cond_o[b]`, where b is the current buffer. It pulses `frame_irq_o` when `irq_mask_i[0]` is set. In dual mode it then switches to the other buffer.
- R9: Line requests have `rd_line_o`=1 and come in ascending line order. Each has length stride = width*bpp/8 bytes and address top + offset + line*stride.
- R10: With `sub_en_i` set, `sub_line_i` becomes the first fetched line if `sub_first_i` is 1, or replaces the line count if `sub_first_i` is 0. Without it, lines 0 to height-1 are fetched. The fit check of R7 always uses the full height.
- R11: A request stays valid with stable address, length and kind until `rd_ready_i` accepts it.
- R12: Dropping `en_i` mid-frame abandons the frame, and `busy_o` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable level |
| pal_mode_i | input | 2 | Palette mode: 1 no fetch, 2 no header, other header then pixels |
| dual_i | input | 1 | Alternate between the two buffers |
| irq_mask_i | input | 2 | Bit 0 frame interrupt enable, bit 1 error interrupt enable |
| width_m1_i | input | LW | Pixels per line minus one |
| height_m1_i | input | LW | Lines per frame minus one |
| sub_en_i | input | 1 | Subpanel line limit enable |
| sub_first_i | input | 1 | 1: subpanel line is first line; 0: it is the line count |
| sub_line_i | input | LW | Subpanel line number |
| buf0_top_i | input | AW | Buffer 0 start address |
| buf0_bot_i | input | AW | Buffer 0 end address |
| buf1_top_i | input | AW | Buffer 1 start address |
| buf1_bot_i | input | AW | Buffer 1 end address |
| bound_ok_i | input | 4 | Validity of the four bound addresses |
| frame_tick_i | input | 1 | Start-of-frame pulse |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | AW | Request byte address |
| rd_len_o | output | LW+5 | Request byte length |
| rd_line_o | output | 1 | 1 pixel line, 0 palette header |
| pal_vld_i | input | 1 | First header word returned |
| pal_word_i | input | 16 | First header word |
| busy_o | output | 1 | Frame sequence in progress |
| active_o | output | 1 | Controller running |
| cur_buf_o | output | 2 | Current buffer, 2'b11 when idle |
| cond_o | output | 3 | Sticky conditions: frame on buffer 0, on buffer 1, bound error |
| sync_err_o | output | 1 | Frame overflowed its buffer |
| frame_irq_o | output | 1 | Frame interrupt pulse |
| err_irq_o | output | 1 | Bound error interrupt pulse |

## Verification
The assertions check the cycle-level rules on every cycle. These are request stability under back-pressure, the header length, and the idle state after enable drops. They also check that an interrupt pulse follows its mask and that a sync error or bound error leaves the controller stopped. The arithmetic can only be shown by the bench's scenarios, which compare request lists against computed values. That covers the depth decode, the data offset, the exact-fit boundary of the overflow check, the subpanel line windows, the buffer alternation and the condition bits across frames.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR_REQ, ST_HDR_WAIT, ST_CHECK, ST_LINES
  } ffs_state_e;

  localparam logic [1:0] BUF_NONE  = 2'b11;
  localparam logic [1:0] PMODE_OFF = 2'd1;
  localparam logic [1:0] PMODE_RAW = 2'd2;
  localparam int unsigned HDR_LONG  = 512;
  localparam int unsigned HDR_SHORT = 32;

  // log2 of bits per pixel, 0 marks an unusable code
  function automatic logic [2:0] bpp_log2(input logic [2:0] code);
    case (code)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      3'd4, 3'd5, 3'd6, 3'd7: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/ffs_geom.sv
module ffs_geom
  import ffs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LW   = 10,
  parameter int LENW = LW + 5
) (
  input  logic [2:0]      code,
  input  logic            raw,
  input  logic [LW-1:0]   w_m1,
  input  logic [LW-1:0]   h_m1,
  input  logic [AW-1:0]   top,
  input  logic [AW-1:0]   bot,
  output logic            bad,
  output logic            ovf,
  output logic [AW-1:0]   off,
  output logic [LENW-1:0] stride
);
  // widened so offset + frame bytes and size + 2 never wrap (needs 2*LW+5 <= AW)
  localparam int EW = AW + 2;
  localparam int PW = 2 * LW + 2;

  logic [2:0]    l2;
  logic [LW:0]   w, h;
  logic [PW-1:0] pix;
  logic [EW-1:0] bytes, size, need;

  always_comb begin
    l2     = bpp_log2(code);
    bad    = (l2 == 3'd0);
    w      = {1'b0, w_m1} + 1'b1;
    h      = {1'b0, h_m1} + 1'b1;
    pix    = PW'(w) * PW'(h);
    bytes  = (EW'(pix) << l2) >> 3;
    if (raw)              off = '0;
    else if (code >= 3'd3) off = AW'(HDR_LONG);
    else                  off = AW'(HDR_SHORT);
    size   = EW'(bot - top);
    need   = EW'(off) + bytes;
    ovf    = need > (size + EW'(2));
    stride = (LENW'(w) << l2) >> 3;
  end
endmodule

// File: rtl/ffs_walker.sv
module ffs_walker #(
  parameter int AW   = 32,
  parameter int LW   = 10,
  parameter int LENW = LW + 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [AW-1:0]   base,
  input  logic [LW:0]     first,
  input  logic [LW:0]     lim,
  input  logic [LENW-1:0] stride,
  output logic [AW-1:0]   addr,
  output logic [LENW-1:0] len,
  output logic            last
);
  logic [AW-1:0]   addr_q, addr_d;
  logic [LW:0]     line_q, line_d, lim_q, lim_d;
  logic [LENW-1:0] str_q, str_d;

  always_comb begin
    addr_d = addr_q;
    line_d = line_q;
    lim_d  = lim_q;
    str_d  = str_q;
    if (load) begin
      addr_d = base + AW'(first * stride);
      line_d = first;
      lim_d  = lim;
      str_d  = stride;
    end else if (step) begin
      addr_d = addr_q + AW'(str_q);
      line_d = line_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      line_q <= '0;
      lim_q  <= '0;
      str_q  <= '0;
    end else if (load || step) begin
      addr_q <= addr_d;
      line_q <= line_d;
      lim_q  <= lim_d;
      str_q  <= str_d;
    end
  end

  assign addr = addr_q;
  assign len  = str_q;
  assign last = (line_q + 1'b1) == lim_q;
endmodule

// File: rtl/frame_fetch_seq.sv
module frame_fetch_seq
  import ffs_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [1:0]      pal_mode_i,
  input  logic            dual_i,
  input  logic [1:0]      irq_mask_i,
  input  logic [LW-1:0]   width_m1_i,
  input  logic [LW-1:0]   height_m1_i,
  input  logic            sub_en_i,
  input  logic            sub_first_i,
  input  logic [LW-1:0]   sub_line_i,
  input  logic [AW-1:0]   buf0_top_i,
  input  logic [AW-1:0]   buf0_bot_i,
  input  logic [AW-1:0]   buf1_top_i,
  input  logic [AW-1:0]   buf1_bot_i,
  input  logic [3:0]      bound_ok_i,
  input  logic            frame_tick_i,
  output logic            rd_valid_o,
  input  logic            rd_ready_i,
  output logic [AW-1:0]   rd_addr_o,
  output logic [LW+4:0]   rd_len_o,
  output logic            rd_line_o,
  input  logic            pal_vld_i,
  input  logic [15:0]     pal_word_i,
  output logic            busy_o,
  output logic            active_o,
  output logic [1:0]      cur_buf_o,
  output logic [2:0]      cond_o,
  output logic            sync_err_o,
  output logic            frame_irq_o,
  output logic            err_irq_o
);
  localparam int LENW = LW + 5;

  ffs_state_e st_q, st_d;
  logic       en_q, act_q, act_d, sync_q, sync_d, raw_q, raw_d;
  logic       fint_q, fint_d, eint_q, eint_d;
  logic [1:0] cur_q, cur_d;
  logic [2:0] cond_q, cond_d, code_q, code_d;

  logic            en_rise, bound_bad, sel;
  logic [AW-1:0]   top_sel, bot_sel, g_off, w_addr;
  logic            g_bad, g_ovf, w_last, w_load, w_step, has_lines;
  logic [LENW-1:0] g_stride, w_len;
  logic [LW:0]     first_v, lim_v;

  assign en_rise   = en_i && !en_q;
  assign bound_bad = !bound_ok_i[0] || !bound_ok_i[1] ||
                     (dual_i && (!bound_ok_i[2] || !bound_ok_i[3]));
  assign sel       = cur_q[0];
  assign top_sel   = sel ? buf1_top_i : buf0_top_i;
  assign bot_sel   = sel ? buf1_bot_i : buf0_bot_i;

  assign first_v   = (sub_en_i && sub_first_i) ? {1'b0, sub_line_i} : '0;
  assign lim_v     = (sub_en_i && !sub_first_i) ? {1'b0, sub_line_i}
                                                : ({1'b0, height_m1_i} + 1'b1);
  assign has_lines = first_v < lim_v;

  ffs_geom #(.AW(AW), .LW(LW), .LENW(LENW)) u_geom (
    .code(code_q), .raw(raw_q), .w_m1(width_m1_i), .h_m1(height_m1_i),
    .top(top_sel), .bot(bot_sel), .bad(g_bad), .ovf(g_ovf),
    .off(g_off), .stride(g_stride)
  );

  ffs_walker #(.AW(AW), .LW(LW), .LENW(LENW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(w_load), .step(w_step),
    .base(top_sel + g_off), .first(first_v), .lim(lim_v), .stride(g_stride),
    .addr(w_addr), .len(w_len), .last(w_last)
  );

  always_comb begin
    st_d   = st_q;
    act_d  = act_q;
    sync_d = sync_q;
    raw_d  = raw_q;
    cur_d  = cur_q;
    cond_d = cond_q;
    code_d = code_q;
    fint_d = 1'b0;
    eint_d = 1'b0;
    w_load = 1'b0;
    w_step = 1'b0;
    if (!en_i) begin
      st_d   = ST_IDLE;
      act_d  = 1'b0;
      sync_d = 1'b0;
      cur_d  = BUF_NONE;
    end else if (en_rise) begin
      if (bound_bad) begin
        cond_d[2] = 1'b1;
        eint_d    = irq_mask_i[1];
      end else begin
        act_d = 1'b1;
        cur_d = 2'b00;
      end
    end else begin
      case (st_q)
        ST_IDLE:
          if (frame_tick_i && act_q && pal_mode_i != PMODE_OFF) begin
            raw_d = (pal_mode_i == PMODE_RAW);
            st_d  = (pal_mode_i == PMODE_RAW) ? ST_CHECK : ST_HDR_REQ;
          end
        ST_HDR_REQ:
          if (rd_ready_i) st_d = ST_HDR_WAIT;
        ST_HDR_WAIT:
          if (pal_vld_i) begin
            code_d = pal_word_i[14:12];
            st_d   = ST_CHECK;
          end
        ST_CHECK: begin
          st_d = ST_IDLE;
          if (g_bad) begin
            st_d = ST_IDLE;
          end else if (g_ovf) begin
            sync_d = 1'b1;
            act_d  = 1'b0;
          end else begin
            cond_d[sel] = 1'b1;
            fint_d      = irq_mask_i[0];
            if (dual_i) cur_d = {1'b0, ~sel};
            w_load = 1'b1;
            if (has_lines) st_d = ST_LINES;
          end
        end
        ST_LINES:
          if (rd_ready_i) begin
            w_step = 1'b1;
            if (w_last) st_d = ST_IDLE;
          end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      sync_q <= 1'b0;
      raw_q  <= 1'b0;
      cur_q  <= BUF_NONE;
      cond_q <= '0;
      code_q <= '0;
      fint_q <= 1'b0;
      eint_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      en_q   <= en_i;
      act_q  <= act_d;
      sync_q <= sync_d;
      raw_q  <= raw_d;
      cur_q  <= cur_d;
      cond_q <= cond_d;
      code_q <= code_d;
      fint_q <= fint_d;
      eint_q <= eint_d;
    end
  end

  assign rd_valid_o  = (st_q == ST_HDR_REQ) || (st_q == ST_LINES);
  assign rd_line_o   = (st_q == ST_LINES);
  assign rd_addr_o   = (st_q == ST_HDR_REQ) ? top_sel : w_addr;
  assign rd_len_o    = (st_q == ST_HDR_REQ) ? LENW'(HDR_LONG) : w_len;
  assign busy_o      = (st_q != ST_IDLE);
  assign active_o    = act_q;
  assign cur_buf_o   = cur_q;
  assign cond_o      = cond_q;
  assign sync_err_o  = sync_q;
  assign frame_irq_o = fint_q;
  assign err_irq_o   = eint_q;
endmodule

// File: rtl/ffs_checker.sv
module ffs_checker #(
  parameter int AW = 32,
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_i,
  input logic [1:0]    irq_mask_i,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic [AW-1:0] rd_addr_o,
  input logic [LW+4:0] rd_len_o,
  input logic          rd_line_o,
  input logic          busy_o,
  input logic          active_o,
  input logic [1:0]    cur_buf_o,
  input logic [2:0]    cond_o,
  input logic          sync_err_o,
  input logic          frame_irq_o,
  input logic          err_irq_o
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i && en_i |=> rd_valid_o && $stable(rd_addr_o)
      && $stable(rd_len_o) && $stable(rd_line_o));
  // R12
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !busy_o && !active_o && !rd_valid_o);
  // R2
  buf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cur_buf_o == 2'b11 && !sync_err_o);
  // R4
  hdr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_line_o |-> rd_len_o == (LW+5)'(512));
  // R8
  frame_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq_o |-> $past(irq_mask_i[0]) && (cond_o[0] || cond_o[1]));
  // R7
  sync_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |-> !active_o);
  // R3
  err_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_o |-> $past(irq_mask_i[1]) && !active_o && cond_o[2]);
endmodule

bind frame_fetch_seq ffs_checker #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .irq_mask_i(irq_mask_i),
  .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
  .rd_len_o(rd_len_o), .rd_line_o(rd_line_o), .busy_o(busy_o),
  .active_o(active_o), .cur_buf_o(cur_buf_o), .cond_o(cond_o),
  .sync_err_o(sync_err_o), .frame_irq_o(frame_irq_o), .err_irq_o(err_irq_o)
);

// File: tb/sim_frame_fetch_seq.sv
module sim_frame_fetch_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 10;
  localparam logic [31:0] T0 = 32'h0000_1000;
  localparam logic [31:0] T1 = 32'h0000_8000;

  logic clk, rst_n, en_i, dual_i, sub_en_i, sub_first_i, frame_tick_i;
  logic [1:0] pal_mode_i, irq_mask_i;
  logic [LW-1:0] width_m1_i, height_m1_i, sub_line_i;
  logic [AW-1:0] buf0_top_i, buf0_bot_i, buf1_top_i, buf1_bot_i;
  logic [3:0] bound_ok_i;
  logic rd_valid_o, rd_ready_i, rd_line_o, pal_vld_i;
  logic [AW-1:0] rd_addr_o;
  logic [LW+4:0] rd_len_o;
  logic [15:0] pal_word_i;
  logic busy_o, active_o, sync_err_o, frame_irq_o, err_irq_o;
  logic [1:0] cur_buf_o;
  logic [2:0] cond_o;

  frame_fetch_seq #(.AW(AW), .LW(LW)) u0 (.*);

  int n_cmp = 0, n_bad = 0;
  int rec_n, fint_cnt, eint_cnt, cyc;
  logic [31:0] rec_addr [64];
  logic [31:0] rec_len [64];
  logic        rec_line [64];
  logic stall, hold_ready_low, pal_pend, prev_wait;
  logic [15:0] pal_cfg;
  logic [31:0] prev_addr;
  logic [3:0] rcnt;
  int exp_cur, last_code;
  logic [2:0] exp_cond;
  logic exp_active;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // memory-side responder and monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    rcnt++;
    pal_vld_i = 1'b0;
    if (pal_pend) begin
      pal_vld_i = 1'b1;
      pal_word_i = pal_cfg;
      pal_pend = 1'b0;
    end
    if (frame_irq_o) fint_cnt++;
    if (err_irq_o) eint_cnt++;
    if (prev_wait && en_i) begin
      chk("R11 request held", {31'd0, rd_valid_o}, 32'd1);
      chk("R11 address stable", rd_addr_o, prev_addr);
    end
    rd_ready_i = hold_ready_low ? 1'b0 : (stall ? rcnt[0] : 1'b1);
    prev_wait = rd_valid_o && !rd_ready_i;
    prev_addr = rd_addr_o;
    if (rd_valid_o && rd_ready_i && rec_n < 64) begin
      rec_addr[rec_n] = rd_addr_o;
      rec_len[rec_n]  = 32'(rd_len_o);
      rec_line[rec_n] = rd_line_o;
      rec_n++;
      if (!rd_line_o) pal_pend = 1'b1;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic reenable();
    en_i = 1'b0;
    @(negedge clk);
    chk("R2 idle buffer", {30'd0, cur_buf_o}, 32'd3);
    chk("R2 inactive", {31'd0, active_o}, 32'd0);
    chk("R2 sync cleared", {31'd0, sync_err_o}, 32'd0);
    en_i = 1'b1;
    @(negedge clk);
    chk("R2 active", {31'd0, active_o}, 32'd1);
    chk("R2 buffer 0", {30'd0, cur_buf_o}, 32'd0);
    exp_cur = 0;
    exp_active = 1'b1;
  endtask

  task automatic run_frame(input int pm, input int code, input int wm1, input int hm1,
                           input int sen, input int sfirst, input int sline,
                           input int dl, input int mask, input int slack);
    int l2, off, w, h, bytes, size, stride, first, lim, used, en_n, used_cur;
    logic [31:0] top, bot;
    logic [31:0] ea [64];
    logic [31:0] el [64];
    logic        ek [64];
    logic exp_sync;
    int exp_fint;
    en_n = 0; exp_fint = 0; exp_sync = 1'b0;
    w = wm1 + 1; h = hm1 + 1;
    pal_mode_i = 2'(pm); width_m1_i = LW'(wm1); height_m1_i = LW'(hm1);
    sub_en_i = sen[0]; sub_first_i = sfirst[0]; sub_line_i = LW'(sline);
    dual_i = dl[0]; irq_mask_i = 2'(mask);
    pal_cfg = 16'(code << 12) | 16'h0a5;
    used_cur = exp_cur;
    top = (exp_cur == 1) ? T1 : T0;
    // buffer size chosen so the frame misses the fit limit by `slack` bytes
    l2 = 0;
    if (pm != 1 && exp_active) begin
      if (pm != 2) begin
        ea[en_n] = top; el[en_n] = 512; ek[en_n] = 1'b0; en_n++;
        last_code = code;
      end
      used = last_code;
      l2 = (used == 1) ? 1 : (used == 2) ? 2 : (used == 3) ? 3 : (used >= 4) ? 4 : 0;
    end
    off = (pm == 2) ? 0 : ((last_code >= 3) ? 512 : 32);
    bytes = ((w * h) << l2) >> 3;
    size = (slack > 1000) ? 32'h400 : (off + bytes - 2 + slack);
    bot = top + 32'(size);
    buf0_bot_i = (exp_cur == 1) ? T0 + 32'h400 : bot;
    buf1_bot_i = (exp_cur == 1) ? bot : T1 + 32'h400;
    if (pm != 1 && exp_active && l2 != 0) begin
      if (off + bytes > size + 2) begin
        exp_sync = 1'b1;
        exp_active = 1'b0;
      end else begin
        exp_cond[exp_cur] = 1'b1;
        exp_fint = mask & 1;
        stride = (w << l2) >> 3;
        first = (sen != 0 && sfirst != 0) ? sline : 0;
        lim = (sen != 0 && sfirst == 0) ? sline : h;
        for (int ln = first; ln < lim; ln++) begin
          ea[en_n] = top + 32'(off) + 32'(ln * stride);
          el[en_n] = 32'(stride); ek[en_n] = 1'b1; en_n++;
        end
        if (dl != 0) exp_cur = 1 - exp_cur;
      end
    end
    rec_n = 0; fint_cnt = 0;
    frame_tick_i = 1'b1;
    @(negedge clk);
    frame_tick_i = 1'b0;
    for (int i = 0; i < 3000 && busy_o; i++) @(negedge clk);
    @(negedge clk);
    chk("R4 R5 R9 R10 request count", 32'(rec_n), 32'(en_n));
    for (int i = 0; i < en_n && i < rec_n; i++) begin
      chk(ek[i] ? "R9 R10 R6 line address" : "R4 header address", rec_addr[i], ea[i]);
      chk(ek[i] ? "R9 line length" : "R4 header length", rec_len[i], el[i]);
      chk("R4 R9 request kind", {31'd0, rec_line[i]}, {31'd0, ek[i]});
    end
    chk("R8 R5 condition bits", {29'd0, cond_o}, {29'd0, exp_cond});
    chk("R8 frame interrupt", 32'(fint_cnt), 32'(exp_fint));
    chk("R7 sync error", {31'd0, sync_err_o}, {31'd0, exp_sync});
    chk("R7 R5 active", {31'd0, active_o}, {31'd0, exp_active});
    if (exp_active) chk("R8 buffer index", {30'd0, cur_buf_o}, 32'(exp_cur));
    if (used_cur != exp_cur) chk("R8 dual toggle", 32'(dl), 32'd1);
  endtask

  initial begin
    cyc = 0; rcnt = 0; rec_n = 0; fint_cnt = 0; eint_cnt = 0;
    stall = 1'b0; hold_ready_low = 1'b0; pal_pend = 1'b0; prev_wait = 1'b0;
    pal_cfg = '0; pal_word_i = '0; pal_vld_i = 1'b0; rd_ready_i = 1'b1;
    exp_cur = 3; last_code = 0; exp_cond = '0; exp_active = 1'b0;
    rst_n = 1'b0; en_i = 1'b0; dual_i = 1'b0; sub_en_i = 1'b0; sub_first_i = 1'b0;
    frame_tick_i = 1'b0; pal_mode_i = 2'd0; irq_mask_i = 2'd0;
    width_m1_i = '0; height_m1_i = '0; sub_line_i = '0;
    buf0_top_i = T0; buf1_top_i = T1; buf0_bot_i = T0 + 32'h400; buf1_bot_i = T1 + 32'h400;
    bound_ok_i = 4'hf;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 valid", {31'd0, rd_valid_o}, 32'd0);
    chk("R1 active", {31'd0, active_o}, 32'd0);
    chk("R1 cond", {29'd0, cond_o}, 32'd0);
    chk("R1 buffer idle", {30'd0, cur_buf_o}, 32'd3);
    chk("R1 irqs", {30'd0, frame_irq_o, err_irq_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: tick while disabled does nothing
    run_frame(0, 3, 3, 2, 0, 0, 0, 0, 1, 5000);
    reenable();
    // R6: raw mode with reset code 0 aborts, R5
    run_frame(2, 0, 3, 2, 0, 0, 0, 0, 1, 5000);
    // R4: palette mode 1 fetches nothing
    run_frame(1, 3, 3, 2, 0, 0, 0, 1, 1, 5000);
    // R5 R6 R8 R9 sweep of depth codes, palette modes and sizes
    for (int pmi = 0; pmi < 3; pmi++)
      for (int c = 0; c < 8; c++)
        for (int d = 0; d < 3; d++)
          run_frame((pmi == 0) ? 0 : (pmi == 1) ? 3 : 2, c,
                    (d == 0) ? 3 : (d == 1) ? 7 : 5,
                    (d == 0) ? 2 : (d == 1) ? 0 : 3,
                    0, 0, 0, d & 1, (c + d) & 1, 5000);
    // R7 exact fit boundary then one byte short, both depths
    run_frame(0, 3, 7, 3, 0, 0, 0, 0, 1, 0);
    run_frame(0, 3, 7, 3, 0, 0, 0, 0, 1, -1);
    reenable();
    run_frame(0, 1, 7, 3, 0, 0, 0, 1, 0, 0);
    run_frame(0, 5, 7, 3, 0, 0, 0, 1, 0, -1);
    reenable();
    // R10 subpanel windows
    run_frame(0, 4, 3, 3, 1, 1, 2, 0, 1, 5000);
    run_frame(0, 4, 3, 3, 1, 0, 2, 0, 1, 5000);
    run_frame(0, 4, 3, 3, 1, 1, 5, 0, 1, 5000);
    run_frame(0, 4, 3, 3, 1, 0, 0, 0, 1, 5000);
    run_frame(0, 2, 3, 1, 1, 0, 6, 1, 1, 5000);
    // R11 back-pressure
    stall = 1'b1;
    run_frame(0, 3, 5, 4, 0, 0, 0, 1, 1, 5000);
    run_frame(2, 3, 5, 4, 0, 0, 0, 1, 1, 5000);
    stall = 1'b0;
    // R12 disable mid-frame
    hold_ready_low = 1'b1;
    pal_mode_i = 2'd0;
    frame_tick_i = 1'b1;
    @(negedge clk);
    frame_tick_i = 1'b0;
    chk("R12 request pending", {31'd0, rd_valid_o}, 32'd1);
    en_i = 1'b0;
    @(negedge clk);
    chk("R12 busy dropped", {31'd0, busy_o}, 32'd0);
    chk("R12 valid dropped", {31'd0, rd_valid_o}, 32'd0);
    hold_ready_low = 1'b0;
    reenable();
    // R3 bound checks
    en_i = 1'b0; dual_i = 1'b0; bound_ok_i = 4'b0111; irq_mask_i = 2'b10;
    @(negedge clk);
    eint_cnt = 0;
    en_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 buffer 1 ignored single", {31'd0, active_o}, 32'd1);
    chk("R3 no error pulse", 32'(eint_cnt), 32'd0);
    en_i = 1'b0; dual_i = 1'b1;
    @(negedge clk);
    en_i = 1'b1;
    repeat (2) @(negedge clk);
    exp_cond[2] = 1'b1;
    chk("R3 dual bad stays off", {31'd0, active_o}, 32'd0);
    chk("R3 error pulse", 32'(eint_cnt), 32'd1);
    chk("R3 cond bit 2", {29'd0, cond_o}, {29'd0, exp_cond});
    en_i = 1'b0; bound_ok_i = 4'b1101; irq_mask_i = 2'b00;
    @(negedge clk);
    en_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 masked no pulse", 32'(eint_cnt), 32'd1);
    chk("R3 buf0 bad stays off", {31'd0, active_o}, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule